// File: doc/BRIEF.md
# Write-Completion Status Read Logic

This block sits on the read path of a byte-wide nonvolatile memory. It lets a host find out whether an internal programming cycle is still running. When no programming is in progress, a read returns the array contents unchanged. While the programming engine reports busy, every read returns a status byte instead of array data, and the status byte carries two independent completion indicators.

- **Polled bit:** bit 7 is the inverse of bit 7 of the most recently written byte. It returns to the true value once programming finishes.
- **Toggling bit:** bit 6 flips each time a new read strobe starts.

A host can poll either bit, and it may begin polling at any point in the busy window. A fresh status read is started by pulsing the output enable, the chip enable, or both. All strobe inputs are active low.

The block is synchronous to the memory controller clock. A read strobe is the combination chip enable low, output enable low and write enable high. The block drives the byte lanes together with an output enable for the external tri-state driver. Analog bus timing is outside this block.

Top module: `wcs_status_read`

## Requirements
- R1: `rd_oe_o` is 1 exactly when `cs_n_i` = 0, `oe_n_i` = 0 and `wr_n_i` = 1. A low write enable or a high chip/output enable gives `rd_oe_o` = 0.
- R2: Whenever `rd_oe_o` is 0, `rd_data_o` is all zeros.
- R3: During a read with `busy_i` = 1, `rd_data_o[7]` equals the inverse of `last_wr_i[7]`.
- R4: A read strobe starts in a cycle where the strobe is active and was not active in the previous cycle. During a busy read, `rd_data_o[6]` is the inverse of the value shown by the previous busy read, and it holds constant for as long as the strobe stays active. The first busy read after reset shows 1.
- R5: During a busy read, `rd_data_o[5:0]` equals `last_wr_i[5:0]` (default fill option).
- R6: During a read with `busy_i` = 0, `rd_data_o` equals `array_data_i` on all 8 bits.
- R7: Read strobes made while `busy_i` = 0 do not advance the toggle state. The first busy read after an idle period therefore shows the inverse of the bit 6 shown by the last busy read before that period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_n_i | input | 1 | Chip enable, active low |
| oe_n_i | input | 1 | Output enable, active low |
| wr_n_i | input | 1 | Write enable, active low |
| busy_i | input | 1 | Programming cycle in progress |
| last_wr_i | input | 8 | Last data byte accepted for programming |
| array_data_i | input | 8 | Data read from the storage array |
| rd_data_o | output | 8 | Byte presented to the bus |
| rd_oe_o | output | 1 | Drive enable for the tri-state bus |

## Verification
The bench targets the toggle bit at strobe boundaries.

- **Strobe held across cycles.** A design that advanced the toggle once per clock would flip bit 6 within a single long strobe.
- **Strobe made while idle.** A design that advanced the toggle on idle reads would break the alternation seen across separate busy periods.
- **Write enable held low with both enables asserted.** A design that treated this as a read would drive the bus during a write.
- **Busy clearing between strobes.** A design that kept showing status after busy dropped would hide the true array byte from the host.

// File: rtl/wcs_pkg.sv
package wcs_pkg;
   typedef enum logic [0:0] {
      FILL_ZERO = 1'b0,
      FILL_LAST = 1'b1
   } fill_e;

   typedef struct packed {
      logic active;
      logic start;
   } strobe_t;
endpackage

// File: rtl/wcs_strobe_detect.sv
module wcs_strobe_detect
   import wcs_pkg::*;
(
   input  logic    clk,
   input  logic    rst_n,
   input  logic    cs_n_i,
   input  logic    oe_n_i,
   input  logic    wr_n_i,
   output strobe_t strobe_o
);
   logic active;
   logic active_q;

   assign active = ~cs_n_i & ~oe_n_i & wr_n_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) active_q <= 1'b0;
      else        active_q <= active;
   end

   assign strobe_o.active = active;
   assign strobe_o.start  = active & ~active_q;
endmodule

// File: rtl/wcs_toggle_track.sv
module wcs_toggle_track
   import wcs_pkg::*;
#(
   parameter logic TOG_RESET = 1'b0
)(
   input  logic    clk,
   input  logic    rst_n,
   input  strobe_t strobe_i,
   input  logic    busy_i,
   output logic    shown_o
);
   logic tog_q;

   // advance once per strobe start, only during a busy window
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                           tog_q <= TOG_RESET;
      else if (strobe_i.start && busy_i)    tog_q <= ~tog_q;
   end

   // first cycle of a strobe shows the value the flop takes at the edge
   assign shown_o = (strobe_i.start && busy_i) ? ~tog_q : tog_q;
endmodule

// File: rtl/wcs_status_mux.sv
module wcs_status_mux
   import wcs_pkg::*;
#(
   parameter int    DATA_W     = 8,
   parameter int    POLL_BIT   = 7,
   parameter int    TOGGLE_BIT = 6,
   parameter fill_e FILL       = FILL_LAST
)(
   input  strobe_t             strobe_i,
   input  logic                busy_i,
   input  logic                tog_i,
   input  logic [DATA_W-1:0]   last_wr_i,
   input  logic [DATA_W-1:0]   array_data_i,
   output logic [DATA_W-1:0]   rd_data_o
);
   logic [DATA_W-1:0] status;

   for (genvar i = 0; i < DATA_W; i++) begin : g_lane
      if (i == POLL_BIT) begin : g_poll
         assign status[i] = ~last_wr_i[i];
      end else if (i == TOGGLE_BIT) begin : g_tog
         assign status[i] = tog_i;
      end else if (FILL == FILL_LAST) begin : g_fill_last
         assign status[i] = last_wr_i[i];
      end else begin : g_fill_zero
         assign status[i] = 1'b0;
      end
   end

   always_comb begin
      if (!strobe_i.active) rd_data_o = '0;
      else if (busy_i)      rd_data_o = status;
      else                  rd_data_o = array_data_i;
   end
endmodule

// File: rtl/wcs_status_read.sv
module wcs_status_read
   import wcs_pkg::*;
#(
   parameter int    DATA_W     = 8,
   parameter int    POLL_BIT   = 7,
   parameter int    TOGGLE_BIT = 6,
   parameter fill_e FILL       = FILL_LAST,
   parameter logic  TOG_RESET  = 1'b0
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n_i,
   input  logic              oe_n_i,
   input  logic              wr_n_i,
   input  logic              busy_i,
   input  logic [DATA_W-1:0] last_wr_i,
   input  logic [DATA_W-1:0] array_data_i,
   output logic [DATA_W-1:0] rd_data_o,
   output logic              rd_oe_o
);
   if (DATA_W < 2) begin : g_bad_width
      $error("wcs_status_read: DATA_W must be at least 2");
   end
   if (POLL_BIT == TOGGLE_BIT) begin : g_bad_lanes
      $error("wcs_status_read: status lanes must differ");
   end
   if (POLL_BIT >= DATA_W || TOGGLE_BIT >= DATA_W) begin : g_bad_range
      $error("wcs_status_read: status lane outside data width");
   end

   strobe_t strobe;
   logic    tog_shown;

   wcs_strobe_detect u_strobe (
      .clk      (clk),
      .rst_n    (rst_n),
      .cs_n_i   (cs_n_i),
      .oe_n_i   (oe_n_i),
      .wr_n_i   (wr_n_i),
      .strobe_o (strobe)
   );

   wcs_toggle_track #(.TOG_RESET(TOG_RESET)) u_tog (
      .clk      (clk),
      .rst_n    (rst_n),
      .strobe_i (strobe),
      .busy_i   (busy_i),
      .shown_o  (tog_shown)
   );

   wcs_status_mux #(
      .DATA_W     (DATA_W),
      .POLL_BIT   (POLL_BIT),
      .TOGGLE_BIT (TOGGLE_BIT),
      .FILL       (FILL)
   ) u_mux (
      .strobe_i     (strobe),
      .busy_i       (busy_i),
      .tog_i        (tog_shown),
      .last_wr_i    (last_wr_i),
      .array_data_i (array_data_i),
      .rd_data_o    (rd_data_o)
   );

   assign rd_oe_o = strobe.active;
endmodule

// File: rtl/wcs_checker.sv
module wcs_checker #(
   parameter int DATA_W     = 8,
   parameter int POLL_BIT   = 7,
   parameter int TOGGLE_BIT = 6
)(
   input logic              clk,
   input logic              rst_n,
   input logic              cs_n_i,
   input logic              oe_n_i,
   input logic              wr_n_i,
   input logic              busy_i,
   input logic [DATA_W-1:0] last_wr_i,
   input logic [DATA_W-1:0] array_data_i,
   input logic [DATA_W-1:0] rd_data_o,
   input logic              rd_oe_o
);
   logic have_prev;
   logic prev_tog;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         have_prev <= 1'b0;
         prev_tog  <= 1'b0;
      end else if (rd_oe_o && busy_i) begin
         have_prev <= 1'b1;
         prev_tog  <= rd_data_o[TOGGLE_BIT];
      end
   end

   a_r1_write_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_n_i) |-> !rd_oe_o);

   a_r2_quiet_bus: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_oe_o) |-> (rd_data_o == '0));

   a_r3_poll_inverse: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_oe_o && busy_i) |-> (rd_data_o[POLL_BIT] != last_wr_i[POLL_BIT]));

   a_r4_flip_per_read: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(rd_oe_o) && busy_i && have_prev) |-> (rd_data_o[TOGGLE_BIT] != prev_tog));

   a_r4_hold_in_read: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_oe_o && busy_i && $past(rd_oe_o) && $past(busy_i)) |-> $stable(rd_data_o[TOGGLE_BIT]));

   a_r6_true_data: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_oe_o && !busy_i) |-> (rd_data_o == array_data_i));
endmodule

bind wcs_status_read wcs_checker #(
   .DATA_W     (DATA_W),
   .POLL_BIT   (POLL_BIT),
   .TOGGLE_BIT (TOGGLE_BIT)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .cs_n_i       (cs_n_i),
   .oe_n_i       (oe_n_i),
   .wr_n_i       (wr_n_i),
   .busy_i       (busy_i),
   .last_wr_i    (last_wr_i),
   .array_data_i (array_data_i),
   .rd_data_o    (rd_data_o),
   .rd_oe_o      (rd_oe_o)
);

// File: tb/tb_wcs_status_read.sv
module tb_wcs_status_read;
   logic       clk = 1'b0;
   logic       rst_n;
   logic       cs_n, oe_n, wr_n, busy;
   logic [7:0] last_wr, arr;
   logic [7:0] rd_data;
   logic       rd_oe;

   always #10 clk = ~clk;

   wcs_status_read dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .cs_n_i       (cs_n),
      .oe_n_i       (oe_n),
      .wr_n_i       (wr_n),
      .busy_i       (busy),
      .last_wr_i    (last_wr),
      .array_data_i (arr),
      .rd_data_o    (rd_data),
      .rd_oe_o      (rd_oe)
   );

   int n_run  = 0;
   int n_fail = 0;
   bit tog_m  = 1'b0;   // toggle value of the last busy read (R4, R7)
   bit prev_m = 1'b0;   // strobe active in previous cycle

   task automatic check(string req, logic [7:0] act, logic [7:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] exp_data(bit rd, bit bsy, logic [7:0] lw,
                                            logic [7:0] a, bit b6);
      if (!rd)  return 8'h00;
      if (!bsy) return a;
      return {~lw[7], b6, lw[5:0]};
   endfunction

   task automatic step(bit c, bit o, bit w, bit b, logic [7:0] lw,
                       logic [7:0] a, string tag);
      bit   rd, b6;
      @(negedge clk);
      cs_n = c; oe_n = o; wr_n = w; busy = b; last_wr = lw; arr = a;
      #5;
      rd = !c && !o && w;
      b6 = (rd && !prev_m && b) ? ~tog_m : tog_m;
      check("R1 oe", {7'd0, rd_oe}, {7'd0, rd});
      if (tag != "")     check(tag, rd_data, exp_data(rd, b, lw, a, b6));
      else if (!rd)      check("R2 idle", rd_data, 8'h00);
      else if (b)        check("R3 R4 R5 status", rd_data, exp_data(rd, b, lw, a, b6));
      else               check("R6 array", rd_data, a);
      @(posedge clk);
      #1;
      if (rd && !prev_m && b) tog_m = ~tog_m;
      prev_m = rd;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired R1");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      bit ok;
      rst_n = 1'b0; cs_n = 1'b1; oe_n = 1'b1; wr_n = 1'b1; busy = 1'b0;
      last_wr = 8'h00; arr = 8'h00;
      repeat (3) @(posedge clk);
      #5;
      check("R2 reset data", rd_data, 8'h00);
      check("R1 reset oe", {7'd0, rd_oe}, 8'h00);
      @(negedge clk);
      rst_n = 1'b1;

      // R1: write enable low blocks read
      step(0, 0, 0, 1, 8'hC3, 8'h5A, "R1 write no read");
      // R4: first busy read shows 1 and holds over a long strobe
      step(0, 0, 1, 1, 8'hC3, 8'h5A, "R4 first read");
      step(0, 0, 1, 1, 8'hC3, 8'h5A, "R4 held");
      step(0, 0, 1, 1, 8'hC3, 8'h5A, "R4 held");
      // R4: new strobe via output enable toggles
      step(0, 1, 1, 1, 8'hC3, 8'h5A, "R2 gap");
      step(0, 0, 1, 1, 8'hC3, 8'h5A, "R4 second read");
      // R4: new strobe via chip enable toggles
      step(1, 0, 1, 1, 8'hC3, 8'h5A, "R2 gap");
      step(0, 0, 1, 1, 8'h41, 8'h5A, "R3 R5 third read");
      // R6: busy clears, array data returned
      step(1, 1, 1, 0, 8'h41, 8'h5A, "");
      step(0, 0, 1, 0, 8'h41, 8'hA7, "R6 done");
      step(0, 1, 1, 0, 8'h41, 8'hA7, "");
      step(0, 0, 1, 0, 8'h41, 8'h3C, "R6 done");
      step(1, 1, 1, 0, 8'h41, 8'h3C, "");
      // R7: idle reads did not advance the toggle
      step(0, 0, 1, 1, 8'h80, 8'h3C, "R7 resumed");
      step(1, 1, 1, 1, 8'h80, 8'h3C, "");
      step(0, 0, 1, 1, 8'h80, 8'h3C, "R7 next");

      ok = ($urandom(32'h5EED_0007) != 0) || 1'b1;
      for (int i = 0; i < 600; i++) begin
         bit c, o, w, b;
         c = ($urandom % 10) < 2;
         o = ($urandom % 10) < 4;
         w = ($urandom % 10) < 9;
         b = (i / 40) % 2 == 0;
         step(c, o, w, b, 8'($urandom), 8'($urandom), "");
      end

      if (!ok) $display("seed note");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule